// File: doc/BRIEF.md
# Multi-Mode PWM Timer Channel

This block is a single timer channel for a control or power-conversion subsystem. A programmable prescaler divides the input clock into counting ticks. A counter steps on those ticks in one of three directions: upward with wrap, downward with reload, or up then down like a triangle. A compare stage turns the running count into a PWM pin level and a compare-match flag. When the counter reaches a period boundary it raises a one-clock update pulse.

The period limit and the compare threshold pass through shadow registers. A new value written to an input therefore takes effect only at the next kept update event, or at once while the channel is disabled. This stops a duty or period change from splitting a PWM period. In triangle counting the caller can keep the update event at the peak, at the valley, or at both. In up or down counting a period lasts (PSC+1)*(ARR+1) input clocks.

Top module: `pwm_timer_channel`

## Requirements
- R1: While enabled, the count changes on exactly one clock in every PSC+1 clocks. A prescale value of 0 lets it change on every clock.
- R2: With mode 0 (mode 3 behaves the same), the count steps 0, 1, ..., ARR and then returns to 0. The tick that leaves ARR is an update event.
- R3: With mode 1, the count steps down to 0. The next tick loads the current `period_i` value and is an update event.
- R4: With mode 2, the count rises to ARR and then falls back to 0, turning at each end. Leaving ARR is a peak event and leaving 0 is a valley event. The event select field keeps both events (00 or 11), the peak only (01) or the valley only (10). When ARR is 0 the count stays at 0.
- R5: `pwm_o` is high exactly when the count is below the active compare value. So 0 gives a constant low, a value above ARR gives a constant high, and mode 2 gives a pulse centred on the valley.
- R6: `match_o` is high exactly while the count equals the active compare value, which lasts one prescaled tick per match.
- R7: The active period and compare values are loaded from `period_i` and `compare_i` only on a kept update event, or on any clock while `en_i` is low.
- R8: While `en_i` is low, the count and the prescaler phase hold their values and no update pulse is raised.
- R9: `update_o` is high for one clock, and that clock is the first one in which the count shows its post-event value.
- R10: During reset the count is 0 and `update_o`, `match_o` and `pwm_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Counting enable |
| prescale_i | input | PSC_W | Prescale value; ticks occur every value+1 clocks |
| period_i | input | CNT_W | Period limit (ARR), preloaded |
| compare_i | input | CNT_W | Compare threshold, preloaded |
| mode_i | input | 2 | 0 up, 1 down, 2 triangle, 3 up |
| evt_sel_i | input | 2 | Triangle update selection: 01 peak, 10 valley, else both |
| count_o | output | CNT_W | Current count |
| update_o | output | 1 | One-clock update pulse |
| match_o | output | 1 | Count equals active compare |
| pwm_o | output | 1 | PWM pin level |

## Verification
The bench sweeps every mode, every event selection, prescale values 0 to 2, period limits 0 to 4 and every compare value from 0 to one above the limit. This covers the constant-low and constant-high duty cases and the ARR=0 degenerate counter. A design that mishandled those ends would show a one-tick glitch on `pwm_o`, or a count that leaves 0. A seeded random phase changes the inputs in mid-period and toggles the enable. This exposes a shadow that loads early, which would cut a PWM period short, and a prescaler that drifts while stalled. A triangle counter with an off-by-one turn would dwell two ticks at the peak or the valley and fail the count comparison at that point.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

   typedef enum logic [1:0] {
      CM_UP     = 2'd0,
      CM_DOWN   = 2'd1,
      CM_CENTER = 2'd2,
      CM_UP_ALT = 2'd3
   } cnt_mode_e;

   localparam logic [1:0] EV_PEAK_ONLY   = 2'b01;
   localparam logic [1:0] EV_VALLEY_ONLY = 2'b10;

endpackage

// File: rtl/pwm_tmr_prescaler.sv
module pwm_tmr_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PSC_W-1:0] psc_i,
   output logic             tick_o
);

   localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

   logic [PSC_W-1:0] phase_q;
   logic [PSC_W-1:0] phase_d;

   // a lowered prescale value while mid-phase ticks at once
   assign tick_o = en_i && (phase_q >= psc_i);

   always_comb begin
      phase_d = phase_q;
      if (en_i) begin
         phase_d = tick_o ? '0 : phase_q + PSC_ONE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_d;
      end
   end

   AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && psc_i != '0) |=> (!tick_o || psc_i == '0)); // R1

   AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i) |=> $stable(phase_q)); // R8

endmodule

// File: rtl/pwm_tmr_counter.sv
module pwm_tmr_counter
   import pwm_timer_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       evt_sel_i,
   input  logic [CNT_W-1:0] arr_act_i,
   input  logic [CNT_W-1:0] arr_in_i,
   output logic             upd_evt_o,
   output logic [CNT_W-1:0] cnt_d_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             upd_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic             rising_q;
   logic             rising_d;
   logic             upd_q;
   logic             wrap_evt;
   logic             peak_evt;
   logic             valley_evt;
   logic             keep_peak;
   logic             keep_valley;

   always_comb begin
      cnt_d      = cnt_q;
      rising_d   = rising_q;
      wrap_evt   = 1'b0;
      peak_evt   = 1'b0;
      valley_evt = 1'b0;
      if (tick_i) begin
         case (cnt_mode_e'(mode_i))
            CM_DOWN: begin
               if (cnt_q == '0) begin
                  cnt_d    = arr_in_i;
                  wrap_evt = 1'b1;
               end else begin
                  cnt_d = cnt_q - CNT_ONE;
               end
            end
            CM_CENTER: begin
               if (rising_q) begin
                  if (cnt_q >= arr_act_i) begin
                     rising_d = 1'b0;
                     peak_evt = 1'b1;
                     cnt_d    = (arr_act_i == '0) ? '0 : arr_act_i - CNT_ONE;
                  end else begin
                     cnt_d = cnt_q + CNT_ONE;
                  end
               end else begin
                  if (cnt_q == '0) begin
                     rising_d   = 1'b1;
                     valley_evt = 1'b1;
                     cnt_d      = (arr_act_i == '0) ? '0 : CNT_ONE;
                  end else begin
                     cnt_d = cnt_q - CNT_ONE;
                  end
               end
            end
            default: begin
               if (cnt_q >= arr_act_i) begin
                  cnt_d    = '0;
                  wrap_evt = 1'b1;
               end else begin
                  cnt_d = cnt_q + CNT_ONE;
               end
            end
         endcase
      end
   end

   assign keep_peak   = (evt_sel_i != EV_VALLEY_ONLY);
   assign keep_valley = (evt_sel_i != EV_PEAK_ONLY);
   assign upd_evt_o   = wrap_evt | (peak_evt & keep_peak) | (valley_evt & keep_valley);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q    <= '0;
         rising_q <= 1'b1;
         upd_q    <= 1'b0;
      end else begin
         cnt_q    <= cnt_d;
         rising_q <= rising_d;
         upd_q    <= upd_evt_o;
      end
   end

   assign cnt_d_o = cnt_d;
   assign cnt_o   = cnt_q;
   assign upd_o   = upd_q;

   AST_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i) |=> ($stable(cnt_q) && !upd_q)); // R8

   AST_UPD_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      upd_q |-> $past(tick_i)); // R9

   AST_UP_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_q && $past(mode_i) == CM_UP) |-> (cnt_q == '0)); // R2

   AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (upd_q && $past(mode_i) == CM_DOWN) |-> (cnt_q == $past(arr_in_i))); // R3

endmodule

// File: rtl/pwm_tmr_shadow.sv
module pwm_tmr_shadow #(
   parameter int CNT_W   = 16,
   parameter bit PRELOAD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             upd_evt_i,
   input  logic [CNT_W-1:0] arr_i,
   input  logic [CNT_W-1:0] ccr_i,
   output logic [CNT_W-1:0] arr_act_o,
   output logic [CNT_W-1:0] ccr_d_o
);

   logic             load;
   logic [CNT_W-1:0] arr_q;
   logic [CNT_W-1:0] ccr_q;

   generate
      if (PRELOAD) begin : g_preload
         assign load = upd_evt_i | ~en_i;

         AST_SHADOW_ARR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!load) |=> $stable(arr_q)); // R7

         AST_SHADOW_CCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!load) |=> $stable(ccr_q)); // R7
      end else begin : g_direct
         assign load = 1'b1;
      end
   endgenerate

   assign ccr_d_o = load ? ccr_i : ccr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         arr_q <= '0;
         ccr_q <= '0;
      end else if (load) begin
         arr_q <= arr_i;
         ccr_q <= ccr_i;
      end
   end

   assign arr_act_o = arr_q;

endmodule

// File: rtl/pwm_tmr_output.sv
module pwm_tmr_output #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] cnt_d_i,
   input  logic [CNT_W-1:0] ccr_d_i,
   output logic             match_o,
   output logic             pwm_o
);

   logic match_q;
   logic pwm_q;

   // registered from next-state values so pin and flag line up with the count
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         match_q <= 1'b0;
         pwm_q   <= 1'b0;
      end else begin
         match_q <= (cnt_d_i == ccr_d_i);
         pwm_q   <= (cnt_d_i < ccr_d_i);
      end
   end

   assign match_o = match_q;
   assign pwm_o   = pwm_q;

   AST_MATCH_NOT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      match_q |-> !pwm_q); // R5

endmodule

// File: rtl/pwm_timer_channel.sv
module pwm_timer_channel #(
   parameter int CNT_W   = 16,
   parameter int PSC_W   = 16,
   parameter bit PRELOAD = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [PSC_W-1:0] prescale_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] compare_i,
   input  logic [1:0]       mode_i,
   input  logic [1:0]       evt_sel_i,
   output logic [CNT_W-1:0] count_o,
   output logic             update_o,
   output logic             match_o,
   output logic             pwm_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("pwm_timer_channel: CNT_W must lie in 2..32");
      end
      if (PSC_W < 1 || PSC_W > 32) begin : g_bad_psc_w
         $error("pwm_timer_channel: PSC_W must lie in 1..32");
      end
   endgenerate

   logic             tick;
   logic             upd_evt;
   logic [CNT_W-1:0] arr_act;
   logic [CNT_W-1:0] ccr_d;
   logic [CNT_W-1:0] cnt_d;

   pwm_tmr_prescaler #(.PSC_W(PSC_W)) u_prescaler (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .psc_i  (prescale_i),
      .tick_o (tick)
   );

   pwm_tmr_counter #(.CNT_W(CNT_W)) u_counter (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .tick_i    (tick),
      .mode_i    (mode_i),
      .evt_sel_i (evt_sel_i),
      .arr_act_i (arr_act),
      .arr_in_i  (period_i),
      .upd_evt_o (upd_evt),
      .cnt_d_o   (cnt_d),
      .cnt_o     (count_o),
      .upd_o     (update_o)
   );

   pwm_tmr_shadow #(.CNT_W(CNT_W), .PRELOAD(PRELOAD)) u_shadow (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .upd_evt_i (upd_evt),
      .arr_i     (period_i),
      .ccr_i     (compare_i),
      .arr_act_o (arr_act),
      .ccr_d_o   (ccr_d)
   );

   pwm_tmr_output #(.CNT_W(CNT_W)) u_output (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_d_i (cnt_d),
      .ccr_d_i (ccr_d),
      .match_o (match_o),
      .pwm_o   (pwm_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      (!rst_ni) |-> (count_o == '0 && !update_o && !match_o && !pwm_o)); // R10

endmodule

// File: tb/pwm_timer_channel_bench.sv
`timescale 1ns/1ps
module pwm_timer_channel_bench;

   localparam int CNT_W = 16;
   localparam int PSC_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [PSC_W-1:0] psc = '0;
   logic [CNT_W-1:0] arr = '0;
   logic [CNT_W-1:0] ccr = '0;
   logic [1:0]       mode = 2'd0;
   logic [1:0]       sel = 2'd0;
   logic [CNT_W-1:0] count;
   logic             upd;
   logic             match;
   logic             pwm;

   always #2.5 clk = ~clk;

   pwm_timer_channel u_pwm_timer_channel (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .en_i       (en),
      .prescale_i (psc),
      .period_i   (arr),
      .compare_i  (ccr),
      .mode_i     (mode),
      .evt_sel_i  (sel),
      .count_o    (count),
      .update_o   (upd),
      .match_o    (match),
      .pwm_o      (pwm)
   );

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   string phase = "reset";

   // reference state, stepped once per clock from the requirements
   int m_pc = 0, m_cnt = 0, m_arr = 0, m_ccr = 0;
   bit m_rise = 1'b1, m_upd = 1'b0, m_cmp = 1'b0, m_pwm = 1'b0;

   task automatic chk(string req, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s [%s]: got %0d expected %0d", req, what, phase, got, exp);
      end
   endtask

   task automatic model_step();
      bit tick, wrap, peak, valley, evt;
      tick = en && (m_pc >= int'(psc));
      if (en) m_pc = tick ? 0 : m_pc + 1;
      wrap = 0; peak = 0; valley = 0;
      if (tick) begin
         if (mode == 2'd1) begin
            if (m_cnt == 0) begin m_cnt = int'(arr); wrap = 1; end
            else m_cnt = m_cnt - 1;
         end else if (mode == 2'd2) begin
            if (m_rise) begin
               if (m_cnt >= m_arr) begin
                  m_rise = 0; peak = 1; m_cnt = (m_arr == 0) ? 0 : m_arr - 1;
               end else m_cnt = m_cnt + 1;
            end else begin
               if (m_cnt == 0) begin
                  m_rise = 1; valley = 1; m_cnt = (m_arr == 0) ? 0 : 1;
               end else m_cnt = m_cnt - 1;
            end
         end else begin
            if (m_cnt >= m_arr) begin m_cnt = 0; wrap = 1; end
            else m_cnt = m_cnt + 1;
         end
      end
      evt = wrap || (peak && sel != 2'b10) || (valley && sel != 2'b01);
      m_upd = evt;
      if (!en || evt) begin m_arr = int'(arr); m_ccr = int'(ccr); end
      m_cmp = (m_cnt == m_ccr);
      m_pwm = (m_cnt < m_ccr);
   endtask

   function automatic string cnt_tag(logic [1:0] md);
      if (md == 2'd1) return "R1,R3";
      if (md == 2'd2) return "R1,R4";
      return "R1,R2";
   endfunction

   task automatic cycle();
      model_step();
      @(posedge clk);
      @(negedge clk);
      chk(cnt_tag(mode), "count", int'(count), m_cnt);
      chk((mode == 2'd2) ? "R4,R9" : "R9", "update", int'(upd), int'(m_upd));
      chk("R6", "match", int'(match), int'(m_cmp));
      chk("R5", "pwm", int'(pwm), int'(m_pwm));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got no finish expected finish within limit");
         $display("[TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin : stimulus
      logic [15:0] lfsr;
      // R10: reset holds everything low even with enable and a fast prescale
      en = 1'b1; psc = '0; arr = 16'd3; ccr = 16'd2;
      repeat (3) @(negedge clk);
      chk("R10", "reset count", int'(count), 0);
      chk("R10", "reset update", int'(upd), 0);
      chk("R10", "reset match", int'(match), 0);
      chk("R10", "reset pwm", int'(pwm), 0);
      en = 1'b0;
      rst_n = 1'b1;

      // near-exhaustive sweep
      for (int md = 0; md < 4; md++) begin
         for (int sl = 0; sl < 4; sl++) begin
            for (int p = 0; p < 3; p++) begin
               for (int a = 0; a < 5; a++) begin
                  for (int c = 0; c <= a + 1; c++) begin
                     phase = "R8 stalled load";
                     en = 1'b0; mode = 2'(md); sel = 2'(sl);
                     psc = PSC_W'(p); arr = CNT_W'(a); ccr = CNT_W'(c);
                     repeat (2) cycle();
                     phase = "sweep";
                     en = 1'b1;
                     repeat ((p + 1) * (2 * a + 3) + 2) cycle();
                  end
               end
            end
         end
      end

      // R7: mid-period changes to the preloaded values, with enable toggles
      phase = "R7 preload";
      lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[3:0] == 4'd0) begin
            arr = CNT_W'(lfsr[7:4] % 10);
         end
         if (lfsr[3:0] == 4'd1) begin
            ccr = CNT_W'(lfsr[11:8] % 12);
         end
         if (lfsr[5:0] == 6'd2) begin
            mode = lfsr[9:8];
            sel  = lfsr[11:10];
         end
         if (lfsr[6:0] == 7'd3) psc = PSC_W'(lfsr[13:12]);
         en = (lfsr[15:12] != 4'd0);
         phase = en ? "R7 preload" : "R8 hold";
         cycle();
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

endmodule